// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block is a hardware walker that turns a 32-bit virtual address into a physical address. The address is cut into a segment number, a virtual page number and a page offset. A small table indexed by segment number gives, for each segment, the base address of that segment's page table, a page-count limit, and a flag that says whether the base is a physical address or itself a virtual one. The walker reads one 32-bit page-table entry (PTE) from memory and joins its physical page number with the original offset.

When a segment's table base is virtual, the computed PTE address is a virtual address in its own right. The walker first translates it through the segment that address names, which must hold a physical table base, and only then fetches the PTE. One segment, chosen by parameter, is the system segment that holds the page tables of the others. A virtual base in the system segment is refused, so the walk is never more than two levels deep.

Translations use a valid/ready request and response pair, one walk at a time. Page-table entries are read over a word-read port whose data comes back after a variable number of cycles. Segment entries are loaded through a separate write port.

Top module: `segpage_xlate`

## Requirements
- R1: A virtual address carries the segment in bits [31:30], the page number in bits [29:12] and the offset in bits [11:0]. For a segment whose entry is marked physical, the walker makes exactly one memory read at table base + 4 x page number. It answers with PA = {PTE[31:12], VA[11:0]} and the fault flag low.
- R2: If the page number is greater than or equal to the segment's limit, the response has the fault flag set and no memory read is made. A page number of limit - 1 translates normally.
- R3: For a segment marked virtual (and not the system segment), the PTE address X = base + 4 x page number is itself translated. The walker reads the word at the base of segment X[31:30] + 4 x X[29:12], forms {word[31:12], X[11:0]}, reads the PTE there, and answers as in R1, using exactly two memory reads.
- R4: A request to the system segment (index 3 by default) while that segment is marked virtual faults with no memory read.
- R5: In the R3 case, if the segment X[31:30] is not marked physical, or X[29:12] is greater than or equal to its limit, the response faults with no memory read.
- R6: PTE bits [11:0] (permission bits) have no effect on the physical address.
- R7: req_ready is high only while no walk is in progress. A response stays valid with a stable address and fault flag until rsp_ready is high at a clock edge, and the walker is then ready again in the following cycle.
- R8: A segment write with seg_we high at a clock edge sets the base, limit and physical flag of entry seg_widx. Requests accepted afterwards use the new values.
- R9: After reset, req_ready is high, rsp_valid and mem_req are low, and every segment entry has limit 0, so every request faults.
- R10: The walker issues a new read only after the data of the previous read has arrived with mem_rvalid, whatever the read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation fault |
| seg_we | input | 1 | Segment entry write strobe |
| seg_widx | input | 2 | Segment entry index |
| seg_wbase | input | 32 | Page-table base address |
| seg_wlimit | input | 19 | Number of valid pages |
| seg_wphys | input | 1 | Base is physical (1) or virtual (0) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions rely on the memory side giving exactly one mem_rvalid pulse per mem_req, never in the same cycle as the request. They also assume no segment entry is rewritten while a walk is in progress, since a walk reads the table entries only in its lookup cycle. The bench's memory model answers each request once, with a latency that rotates between one and four cycles. Segment writes are made only between walks, after the previous response has been taken.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

  localparam int DEF_ADDR_W  = 32;
  localparam int DEF_SEG_W   = 2;
  localparam int DEF_OFF_W   = 12;
  localparam int DEF_SYS_SEG = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG_LOOKUP,
    ST_PTE_ADDR_XLATE,
    ST_PTE_FETCH,
    ST_DONE
  } walk_st_e;

endpackage

// File: rtl/segpage_segtab.sv
module segpage_segtab #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 2,
  parameter int LIM_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEG_W-1:0]  widx,
  input  logic [ADDR_W-1:0] wbase,
  input  logic [LIM_W-1:0]  wlimit,
  input  logic              wphys,
  input  logic [SEG_W-1:0]  idx_a,
  output logic [ADDR_W-1:0] base_a,
  output logic [LIM_W-1:0]  lim_a,
  output logic              phys_a,
  input  logic [SEG_W-1:0]  idx_b,
  output logic [ADDR_W-1:0] base_b,
  output logic [LIM_W-1:0]  lim_b,
  output logic              phys_b
);

  localparam int NSEG = 1 << SEG_W;

  logic [ADDR_W-1:0] base_v [NSEG];
  logic [LIM_W-1:0]  lim_v  [NSEG];
  logic              phys_v [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic [ADDR_W-1:0] base_q;
    logic [LIM_W-1:0]  lim_q;
    logic              phys_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        lim_q  <= '0;
        phys_q <= 1'b0;
      end else if (we && (widx == SEG_W'(g))) begin
        base_q <= wbase;
        lim_q  <= wlimit;
        phys_q <= wphys;
      end
    end

    assign base_v[g] = base_q;
    assign lim_v[g]  = lim_q;
    assign phys_v[g] = phys_q;
  end

  assign base_a = base_v[idx_a];
  assign lim_a  = lim_v[idx_a];
  assign phys_a = phys_v[idx_a];
  assign base_b = base_v[idx_b];
  assign lim_b  = lim_v[idx_b];
  assign phys_b = phys_v[idx_b];

endmodule

// File: rtl/segpage_walk.sv
module segpage_walk
  import segpage_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEG_W   = 2,
  parameter int OFF_W   = 12,
  parameter int SYS_SEG = 3,
  parameter int LIM_W   = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_va,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_fault,
  output logic [SEG_W-1:0]  idx_a,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [LIM_W-1:0]  lim_a,
  input  logic              phys_a,
  output logic [SEG_W-1:0]  idx_b,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [LIM_W-1:0]  lim_b,
  input  logic              phys_b,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              ev_bound_fault,
  output logic              ev_sys_virt,
  output logic              ev_nest_fault
);

  localparam int VPN_W = ADDR_W - SEG_W - OFF_W;

  function automatic logic [SEG_W-1:0] f_seg(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SEG_W];
  endfunction

  function automatic logic [VPN_W-1:0] f_vpn(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: VPN_W];
  endfunction

  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  // Entry address: table base plus four bytes per page.
  function automatic logic [ADDR_W-1:0] f_pte_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [VPN_W-1:0]  vpn);
    return base + (ADDR_W'(vpn) << 2);
  endfunction

  // Page number of the entry placed above the offset; entry's low bits dropped.
  function automatic logic [ADDR_W-1:0] f_join(input logic [ADDR_W-1:0] pte,
                                               input logic [OFF_W-1:0]  off);
    return {pte[ADDR_W-1:OFF_W], off};
  endfunction

  function automatic logic f_over(input logic [VPN_W-1:0] vpn,
                                  input logic [LIM_W-1:0] lim);
    return LIM_W'(vpn) >= lim;
  endfunction

  walk_st_e          st_q;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] ptea_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] pa_q;
  logic              fault_q;
  logic              wait_q;

  logic [ADDR_W-1:0] l_pte_addr;
  logic              l_bound;
  logic              l_sysvirt;
  logic              l_nest;
  logic              l_any_fault;
  logic              in_lookup;
  logic              in_read;

  assign in_lookup  = (st_q == ST_SEG_LOOKUP);
  assign in_read    = (st_q == ST_PTE_ADDR_XLATE) || (st_q == ST_PTE_FETCH);

  assign idx_a      = f_seg(va_q);
  assign l_pte_addr = f_pte_addr(base_a, f_vpn(va_q));
  assign idx_b      = f_seg(l_pte_addr);

  always_comb begin
    l_bound   = f_over(f_vpn(va_q), lim_a);
    l_sysvirt = !phys_a && (idx_a == SEG_W'(SYS_SEG));
    l_nest    = !phys_a && !l_sysvirt && (!phys_b || f_over(f_vpn(l_pte_addr), lim_b));
    l_any_fault = l_bound || l_sysvirt || l_nest;
  end

  assign ev_bound_fault = in_lookup && l_bound;
  assign ev_sys_virt    = in_lookup && !l_bound && l_sysvirt;
  assign ev_nest_fault  = in_lookup && !l_bound && l_nest;

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_DONE);
  assign rsp_pa    = pa_q;
  assign rsp_fault = fault_q;
  assign mem_req   = in_read && !wait_q;
  assign mem_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      ptea_q  <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            fault_q <= 1'b0;
            st_q    <= ST_SEG_LOOKUP;
          end
        end
        ST_SEG_LOOKUP: begin
          if (l_any_fault) begin
            fault_q <= 1'b1;
            pa_q    <= '0;
            st_q    <= ST_DONE;
          end else if (phys_a) begin
            addr_q <= l_pte_addr;
            st_q   <= ST_PTE_FETCH;
          end else begin
            ptea_q <= l_pte_addr;
            addr_q <= f_pte_addr(base_b, f_vpn(l_pte_addr));
            st_q   <= ST_PTE_ADDR_XLATE;
          end
        end
        ST_PTE_ADDR_XLATE: begin
          if (!wait_q) begin
            wait_q <= 1'b1;
          end else if (mem_rvalid) begin
            wait_q <= 1'b0;
            addr_q <= f_join(mem_rdata, f_off(ptea_q));
            st_q   <= ST_PTE_FETCH;
          end
        end
        ST_PTE_FETCH: begin
          if (!wait_q) begin
            wait_q <= 1'b1;
          end else if (mem_rvalid) begin
            wait_q <= 1'b0;
            pa_q   <= f_join(mem_rdata, f_off(va_q));
            st_q   <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import segpage_pkg::*;
#(
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int SEG_W   = DEF_SEG_W,
  parameter int OFF_W   = DEF_OFF_W,
  parameter int SYS_SEG = DEF_SYS_SEG,
  parameter int LIM_W   = ADDR_W - SEG_W - OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic              rsp_fault,
  input  logic              seg_we,
  input  logic [SEG_W-1:0]  seg_widx,
  input  logic [ADDR_W-1:0] seg_wbase,
  input  logic [LIM_W-1:0]  seg_wlimit,
  input  logic              seg_wphys,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata
);

  logic [SEG_W-1:0]  idx_a, idx_b;
  logic [ADDR_W-1:0] base_a, base_b;
  logic [LIM_W-1:0]  lim_a, lim_b;
  logic              phys_a, phys_b;
  logic              ev_bound_fault;
  logic              ev_sys_virt;
  logic              ev_nest_fault;

  segpage_segtab #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .LIM_W(LIM_W)
  ) u_tab (
    .clk(clk), .rst_n(rst_n),
    .we(seg_we), .widx(seg_widx), .wbase(seg_wbase),
    .wlimit(seg_wlimit), .wphys(seg_wphys),
    .idx_a(idx_a), .base_a(base_a), .lim_a(lim_a), .phys_a(phys_a),
    .idx_b(idx_b), .base_b(base_b), .lim_b(lim_b), .phys_b(phys_b)
  );

  segpage_walk #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .OFF_W(OFF_W),
    .SYS_SEG(SYS_SEG), .LIM_W(LIM_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .idx_a(idx_a), .base_a(base_a), .lim_a(lim_a), .phys_a(phys_a),
    .idx_b(idx_b), .base_b(base_b), .lim_b(lim_b), .phys_b(phys_b),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ev_bound_fault(ev_bound_fault), .ev_sys_virt(ev_sys_virt),
    .ev_nest_fault(ev_nest_fault)
  );

endmodule

// File: rtl/segpage_xlate_chk.sv
module segpage_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_pa,
  input logic              rsp_fault,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic              ev_bound_fault,
  input logic              ev_sys_virt,
  input logic              ev_nest_fault
);

  logic [1:0] outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= '0;
    else outst_q <= outst_q + {1'b0, mem_req} - {1'b0, mem_rvalid};
  end

  // R2
  bound_fault_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bound_fault |=> (rsp_valid && rsp_fault && !mem_req));

  // R4
  sys_virt_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sys_virt |=> (rsp_valid && rsp_fault && !mem_req));

  // R5
  nest_fault_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nest_fault |=> (rsp_valid && rsp_fault && !mem_req));

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));

  // R7
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

  // R10
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && (outst_q != 2'd0)));

  // R9
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

endmodule

bind segpage_xlate segpage_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .ev_bound_fault(ev_bound_fault), .ev_sys_virt(ev_sys_virt),
  .ev_nest_fault(ev_nest_fault)
);

// File: tb/sim_segpage_xlate.sv
`timescale 1ns/1ps
module sim_segpage_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa;
  logic        rsp_fault;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_widx = '0;
  logic [31:0] seg_wbase = '0;
  logic [18:0] seg_wlimit = '0;
  logic        seg_wphys = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  segpage_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .seg_we(seg_we), .seg_widx(seg_widx), .seg_wbase(seg_wbase),
    .seg_wlimit(seg_wlimit), .seg_wphys(seg_wphys),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Memory contents and the bench's own copy of the segment table.
  logic [31:0] mem [logic [31:0]];
  logic [31:0] t_base [4];
  int          t_lim  [4];
  bit          t_phys [4];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Memory responder: one answer per request, latency rotating 1..4 cycles.
  bit          pend = 0;
  int          cnt = 0;
  int          lat_sel = 0;
  int          nreads = 0;
  logic [31:0] paddr = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(paddr);
        pend       <= 0;
      end else begin
        cnt <= cnt - 1;
      end
    end
    if (mem_req) begin
      pend    <= 1;
      paddr   <= mem_addr;
      cnt     <= lat_sel;
      lat_sel <= (lat_sel + 1) % 4;
      nreads  <= nreads + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural model of one translation.
  task automatic model(input logic [31:0] va, output bit flt,
                       output logic [31:0] pa, output int reads);
    int s, vpn, s2, vpn2;
    logic [31:0] x, w, pte;
    s = int'(va >> 30); vpn = int'((va >> 12) & 32'h3FFFF);
    flt = 0; pa = 0; reads = 0;
    if (vpn >= t_lim[s]) begin
      flt = 1;
    end else begin
      x = t_base[s] + 32'(vpn * 4);
      if (t_phys[s]) begin
        pte = rd(x); reads = 1;
        pa = (pte & 32'hFFFF_F000) | (va & 32'hFFF);
      end else if (s == 3) begin
        flt = 1;
      end else begin
        s2 = int'(x >> 30); vpn2 = int'((x >> 12) & 32'h3FFFF);
        if (!t_phys[s2] || vpn2 >= t_lim[s2]) begin
          flt = 1;
        end else begin
          w   = rd(t_base[s2] + 32'(vpn2 * 4));
          pte = rd((w & 32'hFFFF_F000) | (x & 32'hFFF));
          reads = 2;
          pa = (pte & 32'hFFFF_F000) | (va & 32'hFFF);
        end
      end
    end
  endtask

  // Per-clock comparison of handshake state against a busy flag (R7).
  bit busy_m = 0;
  always @(posedge clk) begin
    #6;
    if (rst_n && !finished) begin
      chk(req_ready == !busy_m, "R7", "req_ready vs model", 32'(req_ready), 32'(!busy_m));
      if (rsp_valid && !busy_m)
        chk(0, "R7", "response while idle", 32'(rsp_valid), 32'h0);
      if (req_valid && req_ready) busy_m = 1;
      else if (rsp_valid && rsp_ready) busy_m = 0;
    end
  end

  task automatic seg_write(input int idx, input logic [31:0] base,
                           input int lim, input bit phys);
    @(negedge clk);
    seg_we = 1; seg_widx = 2'(idx); seg_wbase = base;
    seg_wlimit = 19'(lim); seg_wphys = phys;
    @(negedge clk);
    seg_we = 0;
    t_base[idx] = base; t_lim[idx] = lim; t_phys[idx] = phys;
  endtask

  task automatic xlate(input logic [31:0] va, input string tag);
    bit          ef;
    logic [31:0] ep;
    logic [31:0] hold;
    int          er, r0, n;
    model(va, ef, ep, er);
    @(negedge clk);
    r0 = nreads;
    req_valid = 1; req_va = va;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid, tag, "response arrives", 32'(rsp_valid), 32'h1);
    chk(rsp_fault == ef, tag, "fault flag", 32'(rsp_fault), 32'(ef));
    if (!ef) chk(rsp_pa == ep, tag, "physical address", rsp_pa, ep);
    hold = rsp_pa;
    @(negedge clk);
    chk(rsp_valid && rsp_pa == hold, "R7", "response held", rsp_pa, hold);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R7", "released to idle", 32'({rsp_valid, req_ready}), 32'h1);
    chk(nreads - r0 == er, tag, "memory read count", 32'(nreads - r0), 32'(er));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      t_base[i] = '0; t_lim[i] = 0; t_phys[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9", "req_ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk(mem_req == 1'b0, "R9", "mem_req after reset", 32'(mem_req), 32'h0);
    xlate(32'h0000_5123, "R9");

    seg_write(0, 32'h0010_0000, 32'h100, 1);
    seg_write(3, 32'h0020_0000, 32'h20, 1);
    seg_write(1, 32'hC000_0000, 32'h40000, 0);
    seg_write(2, 32'h4000_0000, 32'h40000, 0);
    mem[32'h0010_0014] = 32'hABCD_EFFF;
    mem[32'h0010_03FC] = 32'h1234_5000;
    mem[32'h0020_0020] = 32'h0034_5003;
    mem[32'h0034_5008] = 32'h7777_7ABC;
    mem[32'h0020_0000] = 32'h0000_A555;
    mem[32'h0030_0014] = 32'h5555_5000;

    xlate(32'h0000_5123, "R1");   // permission bits all set: R6
    xlate(32'h0000_5123, "R6");
    xlate(32'h000F_F7FF, "R2");   // last page below the limit
    xlate(32'h0010_0000, "R2");   // page equal to the limit
    xlate(32'hC000_0010, "R1");
    xlate(32'h4200_2DEF, "R3");
    xlate(32'h5000_0000, "R5");   // second-level page over system limit
    xlate(32'h8000_0000, "R5");   // second-level segment is virtual
    for (int k = 0; k < 4; k++) xlate(32'h4200_2DEF, "R10");

    seg_write(0, 32'h0030_0000, 32'h100, 1);
    xlate(32'h0000_5123, "R8");

    seg_write(3, 32'h0020_0000, 32'h20, 0);
    xlate(32'hC000_0010, "R4");
    xlate(32'h4200_2DEF, "R5");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule